// File: doc/BRIEF.md
# Authentication Status Pin Latch

This block drives one status pin that tells the board whether an authentication has succeeded. The pin is either driven high or left floating; an external pull-down turns the floating state into a low level. It is exposed as a data signal and an output-enable signal, and it is never driven low. Whether a command may touch the pin is set per key by a 16-entry table. Each entry holds a signaling-enable bit and a hold bit, and the table is loaded through a simple synchronous write port.

The authentication engine reports every finished authentication command as a single-cycle event. The event carries the two low mode bits, the key index, a checksum-valid flag and a pass/fail result. A passing inbound-only or mutual authentication sets the latch when the named key has signaling enabled. A special reset-mode command clears the latch unless the named key's hold bit is set. The latch keeps no record of which key set it. Nothing else clears it apart from the power-on reset. When the shared pin is assigned to serial data (SPI interface mode), the latch is frozen.

Top module: `auth_sig_latch`

## Requirements
- R1: After the active-low power-on reset, pin_oe and pin_do are 0, and every table entry reads enable=0 and hold=0. A passing authentication on any key therefore leaves the pin released.
- R2: A command with cmd_valid=1, cmd_crc_ok=1, cmd_pass=1 and cmd_mode[0]=1 (mode 01 is inbound-only, mode 11 is mutual) on a key whose enable bit is 1 sets the latch at the next clock edge. Later non-reset commands leave it set.
- R3: When the named key's enable bit is 0, a non-reset command leaves the pin unchanged, whether it passes or fails.
- R4: A failed non-reset command, or any command with cmd_crc_ok=0, leaves the pin unchanged.
- R5: An authentication reset (cmd_mode=00, cmd_crc_ok=1) on a key whose hold bit is 0 releases the pin at the next edge. This does not depend on cmd_pass or on that key's enable bit.
- R6: An authentication reset on a key whose hold bit is 1 leaves the pin unchanged.
- R7: Outbound-only mode (cmd_mode=10) never sets the latch, even when it passes on an enabled key.
- R8: While if_spi=1 no command changes the pin.
- R9: pin_do equals pin_oe. The pin is only ever driven high or released, never driven low.
- R10: cfg_wdata bit 0 is the enable bit and bit 1 is the hold bit of entry cfg_addr, written at the clock edge where cfg_we=1. A command in that same cycle is judged against the entry's previous contents.
- R11: Each command is judged only against the bits of its own cmd_key. A latch set through one key can be released through a different key whose hold bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 4 | Table entry to write |
| cfg_wdata | input | 2 | bit0 enable, bit1 hold |
| if_spi | input | 1 | 1 = pin assigned to serial data, latch frozen |
| cmd_valid | input | 1 | Single-cycle command-complete event |
| cmd_mode | input | 2 | Low mode bits of the command |
| cmd_key | input | 4 | Key index carried by the command |
| cmd_crc_ok | input | 1 | Command checksum valid |
| cmd_pass | input | 1 | Authentication succeeded |
| pin_do | output | 1 | Pin data, high when latched |
| pin_oe | output | 1 | Pin output enable, 1 = driven |

## Verification
A table write and a command event can land in the same cycle and name the same key. The command must then use the entry's old bits, and the new bits take effect from the following command. The bench provokes this with a directed case that enables a key and fires a passing command on that key in the same cycle, so the pin must stay released and only rise on the next command. Random traffic repeats the collision on a small pool of keys. A reference model that applies the command before the write judges every cycle.

// File: rtl/auth_sig_pkg.sv
package auth_sig_pkg;

  localparam int MODE_W = 2;
  localparam int CFG_W  = 2;

  // bit 1 hold, bit 0 signaling enable (matches cfg_wdata layout)
  typedef struct packed {
    logic hold;
    logic sig_en;
  } key_cfg_t;

  function automatic logic is_auth_reset(input logic [MODE_W-1:0] mode);
    return (mode == '0);
  endfunction

  // inbound-only (01) and mutual (11) both carry the inbound bit
  function automatic logic has_inbound(input logic [MODE_W-1:0] mode);
    return mode[0];
  endfunction

  function automatic key_cfg_t to_cfg(input logic [CFG_W-1:0] raw);
    key_cfg_t c;
    c.sig_en = raw[0];
    c.hold   = raw[1];
    return c;
  endfunction

endpackage

// File: rtl/auth_cfg_table.sv
module auth_cfg_table
  import auth_sig_pkg::*;
#(
  parameter int NUM_KEYS = 16,
  localparam int KEY_W = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_addr,
  input  key_cfg_t         wr_cfg,
  input  logic [KEY_W-1:0] rd_addr,
  output key_cfg_t         rd_cfg
);

  key_cfg_t entry_q [NUM_KEYS];

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q[k] <= '0;
      end else if (wr_en && (wr_addr == KEY_W'(k))) begin
        entry_q[k] <= wr_cfg;
      end
    end
  end

  always_comb begin
    rd_cfg = '0;
    for (int k = 0; k < NUM_KEYS; k++) begin
      if (rd_addr == KEY_W'(k)) rd_cfg = entry_q[k];
    end
  end

endmodule

// File: rtl/auth_cmd_decode.sv
module auth_cmd_decode
  import auth_sig_pkg::*;
(
  input  logic              cmd_valid,
  input  logic [MODE_W-1:0] cmd_mode,
  input  logic              cmd_crc_ok,
  input  logic              cmd_pass,
  input  logic              if_spi,
  input  key_cfg_t          key_cfg,
  output logic              set_evt,
  output logic              clr_evt
);

  logic accepted;

  always_comb begin
    accepted = cmd_valid && cmd_crc_ok && !if_spi;
    set_evt  = accepted && !is_auth_reset(cmd_mode) && has_inbound(cmd_mode)
               && cmd_pass && key_cfg.sig_en;
    clr_evt  = accepted && is_auth_reset(cmd_mode) && !key_cfg.hold;
  end

endmodule

// File: rtl/auth_out_latch.sv
module auth_out_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic drive_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
    end else if (set_evt) begin
      drive_q <= 1'b1;
    end else if (clr_evt) begin
      drive_q <= 1'b0;
    end
  end

endmodule

// File: rtl/auth_sig_latch.sv
module auth_sig_latch
  import auth_sig_pkg::*;
#(
  parameter int NUM_KEYS = 16,
  localparam int KEY_W = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [KEY_W-1:0]  cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              if_spi,
  input  logic              cmd_valid,
  input  logic [MODE_W-1:0] cmd_mode,
  input  logic [KEY_W-1:0]  cmd_key,
  input  logic              cmd_crc_ok,
  input  logic              cmd_pass,
  output logic              pin_do,
  output logic              pin_oe
);

  // named internal events, observed by the checker
  key_cfg_t cmd_cfg;
  logic     set_evt;
  logic     clr_evt;
  logic     drive_q;

  auth_cfg_table #(.NUM_KEYS(NUM_KEYS)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_cfg  (to_cfg(cfg_wdata)),
    .rd_addr (cmd_key),
    .rd_cfg  (cmd_cfg)
  );

  auth_cmd_decode u_decode (
    .cmd_valid  (cmd_valid),
    .cmd_mode   (cmd_mode),
    .cmd_crc_ok (cmd_crc_ok),
    .cmd_pass   (cmd_pass),
    .if_spi     (if_spi),
    .key_cfg    (cmd_cfg),
    .set_evt    (set_evt),
    .clr_evt    (clr_evt)
  );

  auth_out_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_evt),
    .clr_evt (clr_evt),
    .drive_q (drive_q)
  );

  assign pin_oe = drive_q;
  assign pin_do = drive_q;

endmodule

// File: rtl/auth_sig_chk.sv
module auth_sig_chk
  import auth_sig_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              if_spi,
  input logic              cmd_valid,
  input logic [MODE_W-1:0] cmd_mode,
  input logic              cmd_crc_ok,
  input logic              cmd_pass,
  input logic              cfg_sig_en,
  input logic              cfg_hold,
  input logic              set_evt,
  input logic              clr_evt,
  input logic              pin_do,
  input logic              pin_oe
);

  // R2
  set_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> pin_oe);

  // R5
  clr_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !pin_oe);

  // R4
  no_cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || !cmd_crc_ok) |=> $stable(pin_oe));

  // R8
  spi_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_spi |=> $stable(pin_oe));

  // R6
  hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode == 2'b00 && cfg_hold) |=> $stable(pin_oe));

  // R3
  disabled_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode != 2'b00 && !cfg_sig_en) |=> $stable(pin_oe));

  // R7
  outbound_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode == 2'b10) |=> $stable(pin_oe));

  // R4
  failed_auth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode != 2'b00 && !cmd_pass) |=> $stable(pin_oe));

  // R9
  pin_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe == pin_do);

endmodule

bind auth_sig_latch auth_sig_chk u_auth_sig_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .if_spi     (if_spi),
  .cmd_valid  (cmd_valid),
  .cmd_mode   (cmd_mode),
  .cmd_crc_ok (cmd_crc_ok),
  .cmd_pass   (cmd_pass),
  .cfg_sig_en (cmd_cfg.sig_en),
  .cfg_hold   (cmd_cfg.hold),
  .set_evt    (set_evt),
  .clr_evt    (clr_evt),
  .pin_do     (pin_do),
  .pin_oe     (pin_oe)
);

// File: tb/test_auth_sig_latch.sv
module test_auth_sig_latch;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [1:0] cfg_wdata = '0;
  logic       if_spi = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_mode = '0;
  logic [3:0] cmd_key = '0;
  logic       cmd_crc_ok = 1'b0;
  logic       cmd_pass = 1'b0;
  logic       pin_do;
  logic       pin_oe;

  int checks = 0;
  int errors = 0;

  logic m_en   [16];
  logic m_hold [16];
  logic m_pin;

  always #5 clk = ~clk;

  auth_sig_latch i_auth_sig_latch (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .if_spi(if_spi), .cmd_valid(cmd_valid),
    .cmd_mode(cmd_mode), .cmd_key(cmd_key), .cmd_crc_ok(cmd_crc_ok),
    .cmd_pass(cmd_pass), .pin_do(pin_do), .pin_oe(pin_oe)
  );

  // reference: next pin value from the requirements
  function automatic logic ref_next(input logic cur, input logic v, input logic [1:0] md,
                                    input logic crc, input logic ok, input logic spi,
                                    input logic en, input logic hd);
    if (!v || !crc || spi) return cur;
    if (md == 2'b00) return hd ? cur : 1'b0;
    if ((md == 2'b01 || md == 2'b11) && ok && en) return 1'b1;
    return cur;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (pin_oe !== m_pin || pin_do !== m_pin) begin
      errors++;
      $display("FAIL %s: pin_oe=%b pin_do=%b expected both %b", tag, pin_oe, pin_do, m_pin);
    end
  endtask

  // drive one cycle at a negedge, advance the model at the posedge, check at next negedge
  task automatic cycle(input logic we, input logic [3:0] wa, input logic [1:0] wd,
                       input logic spi, input logic v, input logic [1:0] md,
                       input logic [3:0] key, input logic crc, input logic ok,
                       input string tag);
    cfg_we = we; cfg_addr = wa; cfg_wdata = wd; if_spi = spi;
    cmd_valid = v; cmd_mode = md; cmd_key = key; cmd_crc_ok = crc; cmd_pass = ok;
    @(posedge clk);
    m_pin = ref_next(m_pin, v, md, crc, ok, spi, m_en[key], m_hold[key]);
    if (we) begin
      m_en[wa]   = wd[0];
      m_hold[wa] = wd[1];
    end
    @(negedge clk);
    cfg_we = 1'b0; cmd_valid = 1'b0;
    check(tag);
  endtask

  task automatic cmd(input logic spi, input logic [1:0] md, input logic [3:0] key,
                     input logic crc, input logic ok, input string tag);
    cycle(1'b0, 4'd0, 2'b00, spi, 1'b1, md, key, crc, ok, tag);
  endtask

  task automatic wr(input logic [3:0] wa, input logic [1:0] wd, input string tag);
    cycle(1'b1, wa, wd, 1'b0, 1'b0, 2'b00, 4'd0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5A17;
    void'($urandom(seed));
    for (int k = 0; k < 16; k++) begin m_en[k] = 1'b0; m_hold[k] = 1'b0; end
    m_pin = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset");

    // R1: table cleared, so a passing mutual auth does nothing
    cmd(1'b0, 2'b11, 4'd3, 1'b1, 1'b1, "R1 table empty");
    // R10: write enable and command on same key in same cycle -> old bits
    cycle(1'b1, 4'd3, 2'b01, 1'b0, 1'b1, 2'b01, 4'd3, 1'b1, 1'b1, "R10 same-cycle old bits");
    cmd(1'b0, 2'b01, 4'd3, 1'b1, 1'b1, "R2 inbound sets");
    cmd(1'b0, 2'b11, 4'd3, 1'b1, 1'b1, "R2 stays set");
    cmd(1'b0, 2'b01, 4'd3, 1'b1, 1'b0, "R4 failed keeps set");
    // R6: hold bit blocks the reset
    wr(4'd5, 2'b10, "R10 write hold key5");
    cmd(1'b0, 2'b00, 4'd5, 1'b1, 1'b0, "R6 hold keeps");
    // R11 + R5: release through a different, unconfigured key, failed result
    cmd(1'b0, 2'b00, 4'd7, 1'b1, 1'b0, "R11 R5 reset other key");
    cmd(1'b0, 2'b01, 4'd3, 1'b0, 1'b1, "R4 bad crc no set");
    cmd(1'b0, 2'b01, 4'd3, 1'b1, 1'b0, "R4 failed no set");
    cmd(1'b0, 2'b10, 4'd3, 1'b1, 1'b1, "R7 outbound only");
    cmd(1'b0, 2'b11, 4'd3, 1'b1, 1'b1, "R2 mutual sets");
    cmd(1'b0, 2'b00, 4'd7, 1'b0, 1'b1, "R5 reset needs crc");
    cmd(1'b1, 2'b00, 4'd7, 1'b1, 1'b1, "R8 spi blocks reset");
    cmd(1'b0, 2'b00, 4'd3, 1'b1, 1'b1, "R5 reset on enabled key");
    cmd(1'b1, 2'b01, 4'd3, 1'b1, 1'b1, "R8 spi blocks set");
    cmd(1'b0, 2'b01, 4'd9, 1'b1, 1'b1, "R3 disabled key pass");
    cmd(1'b0, 2'b11, 4'd9, 1'b1, 1'b0, "R3 disabled key fail");

    // random traffic over a small key pool so writes and commands collide
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] wa, key;
      wa  = 4'($urandom_range(0, 3));
      key = 4'($urandom_range(0, 3));
      cycle(($urandom_range(0, 4) == 0), wa, 2'($urandom),
            ($urandom_range(0, 9) == 0), ($urandom_range(0, 2) != 0), 2'($urandom),
            key, ($urandom_range(0, 9) != 0), 1'($urandom), "R9 R10 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule